// File: doc/BRIEF.md
# Counter-Based Frequency Lock Detector

This block judges whether a VCO clock and a reference clock run at the same frequency. Each clock drives its own counter, and both counters use the same programmable terminal count. Each time either counter wraps, it produces a terminal-count event. The event from the VCO domain is carried into the reference domain with a toggle synchronizer. If the second event follows the first within a fixed tolerance window, the interval is a match. A tally counts consecutive matches, and the lock flag rises once the tally reaches a programmable threshold.

If the window closes while one event is still missing, the block raises a one-cycle mismatch strobe. A mismatch clears the tally, restarts the reference counter at once and sends a restart request to the VCO counter. For a settling period after a mismatch, terminal-count events are ignored, so that events already in the synchronizer cannot open a new window. The block observes the loop and feeds nothing back to it. The terminal count and the threshold are configuration inputs and are meant to be held steady while the block measures.

Top module: `freq_lock_detect`

## Requirements
- R1: While `rst_n` is low, and on the first reference cycle after it is released, `lock` and `mismatch` are both 0.
- R2: When both clocks run at the same frequency, one interval lasts `term_count`+1 reference cycles. `lock` stays 0 until `lock_need` intervals have elapsed since reset release, and rises within about one interval after that. The tally never jumps by more than one.
- R3: When the two terminal-count events lie more than TOL reference cycles apart, the block pulses `mismatch` and `lock` never rises. A VCO at half the reference frequency is one such case.
- R4: `mismatch` is high for exactly one reference cycle per disagreement and never for two cycles in a row.
- R5: `lock` is 0 in any cycle where `mismatch` is high. After a mismatch, `lock` rises again only after `lock_need` new consecutive matches.
- R6: The tally saturates at the threshold. Once high, `lock` stays high for as long as the intervals keep matching.
- R7: A `lock_need` of 0 behaves exactly as a threshold of 1.
- R8: A larger `lock_need` delays lock in proportion: with 6 required matches, `lock` is still 0 after 5 intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all decisions and both outputs are in this domain |
| vco_clk | input | 1 | VCO clock under test |
| rst_n | input | 1 | Asynchronous active-low reset of both domains |
| term_count | input | CNT_W | Terminal count; each counter wraps after reaching it |
| lock_need | input | MATCH_W | Number of consecutive matches required for lock (0 is treated as 1) |
| lock | output | 1 | Frequency-lock flag |
| mismatch | output | 1 | One-cycle strobe when a disagreement resets the measurement |

## Verification
A tally that skips or fails to clear shows up as `lock` rising earlier or later than `lock_need` intervals after reset or after the last `mismatch` strobe. Such an error is visible within one interval of the expected rise. A window that closes too early or too late shows up as spurious strobes at equal frequency, or as a lock at half frequency, within a few intervals. A stuck flag is caught because `lock` must fall in the same cycle as the strobe.

// File: rtl/freq_lock_detect.sv
module freq_lock_detect #(
  parameter int CNT_W   = 16,
  parameter int MATCH_W = 8,
  parameter int TOL     = 10
) (
  input  logic               ref_clk,
  input  logic               vco_clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   term_count,
  input  logic [MATCH_W-1:0] lock_need,
  output logic               lock,
  output logic               mismatch
);
  localparam int TW = $clog2(TOL + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_SETTLE} st_t;

  logic [CNT_W-1:0]   vco_cnt, ref_cnt;
  logic               vco_tgl, rq_tgl;
  logic [2:0]         rq_sync, tc_sync;
  logic               vco_ev, ref_ev, other_ev, hit, expire;
  logic               first_ref;
  logic [TW-1:0]      wcnt;
  logic [MATCH_W-1:0] match_cnt, need_eff;
  st_t                st;

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_sync <= '0;
      vco_cnt <= '0;
      vco_tgl <= 1'b0;
    end else begin
      rq_sync <= {rq_sync[1:0], rq_tgl};
      if (rq_sync[2] ^ rq_sync[1]) begin
        vco_cnt <= '0;
      end else if (vco_cnt == term_count) begin
        vco_cnt <= '0;
        vco_tgl <= ~vco_tgl;
      end else begin
        vco_cnt <= vco_cnt + 1'b1;
      end
    end
  end

  assign vco_ev   = tc_sync[2] ^ tc_sync[1];
  assign ref_ev   = (ref_cnt == term_count);
  assign other_ev = first_ref ? vco_ev : ref_ev;
  assign hit      = ((st == S_IDLE) && ref_ev && vco_ev) || ((st == S_WAIT) && other_ev);
  assign expire   = (st == S_WAIT) && !other_ev && (wcnt == TW'(TOL - 1));
  assign need_eff = (lock_need == '0) ? MATCH_W'(1) : lock_need;
  assign lock     = (match_cnt >= need_eff);

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_sync   <= '0;
      ref_cnt   <= '0;
      rq_tgl    <= 1'b0;
      st        <= S_IDLE;
      first_ref <= 1'b0;
      wcnt      <= '0;
      match_cnt <= '0;
      mismatch  <= 1'b0;
    end else begin
      tc_sync  <= {tc_sync[1:0], vco_tgl};
      mismatch <= expire;

      if (expire)      ref_cnt <= '0;
      else if (ref_ev) ref_cnt <= '0;
      else             ref_cnt <= ref_cnt + 1'b1;

      if (expire) begin
        rq_tgl    <= ~rq_tgl;
        match_cnt <= '0;
      end else if (hit && !lock) begin
        match_cnt <= match_cnt + 1'b1;
      end

      case (st)
        S_IDLE: begin
          wcnt <= '0;
          if (ref_ev ^ vco_ev) begin
            st        <= S_WAIT;
            first_ref <= ref_ev;
          end
        end
        S_WAIT: begin
          if (hit) begin
            st   <= S_IDLE;
            wcnt <= '0;
          end else if (expire) begin
            st   <= S_SETTLE;
            wcnt <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: begin
          if (wcnt == TW'(TOL - 1)) begin
            st   <= S_IDLE;
            wcnt <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/freq_lock_detect_chk.sv
module freq_lock_detect_chk #(
  parameter int MATCH_W = 8
) (
  input logic               ref_clk,
  input logic               rst_n,
  input logic               lock,
  input logic               mismatch,
  input logic [MATCH_W-1:0] lock_need,
  input logic [MATCH_W-1:0] match_cnt
);
  AST_MM_ONE_CYCLE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    mismatch |=> !mismatch); // R4
  AST_MM_CLEARS_LOCK: assert property (@(posedge ref_clk) disable iff (!rst_n)
    mismatch |-> !lock); // R5
  AST_LOCK_HOLD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($fell(lock) && $stable(lock_need)) |-> mismatch); // R6
  AST_TALLY_STEP: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (match_cnt != $past(match_cnt)) |-> (match_cnt == MATCH_W'($past(match_cnt) + 1'b1) || match_cnt == '0)); // R2
  AST_TALLY_SAT: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($past(lock) && $stable(lock_need) && !mismatch) |-> $stable(match_cnt)); // R6
endmodule

bind freq_lock_detect freq_lock_detect_chk #(.MATCH_W(MATCH_W)) u_chk (
  .ref_clk(ref_clk), .rst_n(rst_n), .lock(lock), .mismatch(mismatch),
  .lock_need(lock_need), .match_cnt(match_cnt)
);

// File: tb/freq_lock_detect_tb.sv
`timescale 1ns/1ps
module freq_lock_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int MW = 8;

  logic ref_clk = 1'b0, vco_clk = 1'b0, rst_n = 1'b0;
  logic [CW-1:0] term_count = 16'd15;
  logic [MW-1:0] lock_need = 8'd3;
  logic lock, mismatch;
  real vco_half = 5.0;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, mm_count = 0, mm_wide = 0, last_mm = 0, lock_rise_gap = -1;
  logic prev_mm = 1'b0, prev_lock = 1'b0;

  freq_lock_detect #(.CNT_W(CW), .MATCH_W(MW), .TOL(10)) u_dut (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n),
    .term_count(term_count), .lock_need(lock_need),
    .lock(lock), .mismatch(mismatch)
  );

  initial forever #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  initial begin
    #2;
    forever #(vco_half) vco_clk = ~vco_clk;
  end

  always @(negedge ref_clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (mismatch) begin
        mm_count <= mm_count + 1;
        last_mm  <= cyc;
      end
      if (mismatch && prev_mm) mm_wide <= mm_wide + 1;
      if (lock && !prev_lock && lock_rise_gap < 0) lock_rise_gap <= cyc - last_mm;
    end
    prev_mm   <= mismatch;
    prev_lock <= lock;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic do_reset(input int tc, input int need, input real vh);
    rst_n = 1'b0;
    term_count = CW'(tc);
    lock_need = MW'(need);
    vco_half = vh;
    wait_cycles(4);
    check(lock == 0 && mismatch == 0, "R1 in reset", int'(lock) + 2*int'(mismatch), 0);
    rst_n = 1'b1;
    mm_count = 0; mm_wide = 0;
    wait_cycles(1);
    check(lock == 0 && mismatch == 0, "R1 after release", int'(lock) + 2*int'(mismatch), 0);
  endtask

  task automatic t_equal_lock();
    do_reset(15, 3, 5.0);
    wait_cycles(3*16 - 6);
    check(lock == 0, "R2 early lock", int'(lock), 0);
    wait_cycles(24);
    check(lock == 1, "R2 lock after 3 intervals", int'(lock), 1);
    check(mm_count == 0, "R2 no mismatch at equal freq", mm_count, 0);
  endtask

  task automatic t_hold();
    int drops = 0;
    for (int i = 0; i < 400; i++) begin
      wait_cycles(1);
      if (!lock) drops++;
    end
    check(drops == 0, "R6 lock held", drops, 0);
    check(mm_count == 0, "R6 no mismatch while held", mm_count, 0);
  endtask

  task automatic t_slow();
    int highs = 0;
    do_reset(15, 2, 10.0);
    for (int i = 0; i < 600; i++) begin
      wait_cycles(1);
      if (lock) highs++;
    end
    check(highs == 0, "R3 no lock at half freq", highs, 0);
    check(mm_count > 0, "R3 mismatch seen", mm_count, 1);
    check(mm_wide == 0, "R4 strobe one cycle", mm_wide, 0);
  endtask

  task automatic t_relock();
    do_reset(15, 3, 5.0);
    wait_cycles(70);
    check(lock == 1, "R5 initial lock", int'(lock), 1);
    vco_half = 10.0;
    wait_cycles(80);
    check(mm_count > 0, "R5 mismatch after freq change", mm_count, 1);
    check(lock == 0, "R5 lock cleared", int'(lock), 0);
    vco_half = 5.0;
    lock_rise_gap = -1;
    wait_cycles(300);
    check(lock == 1, "R5 relocked", int'(lock), 1);
    check(lock_rise_gap >= 3*16 - 8, "R5 relock needs full tally", lock_rise_gap, 3*16 - 8);
    check(mm_wide == 0, "R4 strobe one cycle in relock", mm_wide, 0);
  endtask

  task automatic t_zero();
    do_reset(15, 0, 5.0);
    wait_cycles(10);
    check(lock == 0, "R7 not before first interval", int'(lock), 0);
    wait_cycles(22);
    check(lock == 1, "R7 zero acts as one", int'(lock), 1);
  endtask

  task automatic t_long();
    do_reset(15, 6, 5.0);
    wait_cycles(5*16);
    check(lock == 0, "R8 not locked after 5 intervals", int'(lock), 0);
    wait_cycles(16 + 16);
    check(lock == 1, "R8 locked after 6 intervals", int'(lock), 1);
  endtask

  initial begin
    t_equal_lock();
    t_hold();
    t_slow();
    t_relock();
    t_zero();
    t_long();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule